// File: doc/BRIEF.md
# Hold/Toggle Interval Sequencer

This block steers the shift activity of a low-power pattern generator when the generator runs as a deterministic test-data decompressor. Each scan shift period is cut into alternating intervals. During a toggle interval the per-lane hold latches follow the generator, so the scan inputs change. During a hold interval the latches keep their value, so the scan inputs stay quiet. The length of each interval comes from one of two programmable length registers: one for toggle intervals and one for hold intervals. A single down counter is preset from whichever register matches the phase being entered.

At the start of every pattern, the encoder supplies the starting phase and a counter offset that sets how long that first interval lasts. A hold length of zero is reserved as an override: with it, the block reports toggle for the whole pattern. A first-cycle strobe, issued when the generator finishes initialization, reloads every hold latch with the current generator word whatever the phase.

Top module: `ht_interval_seq`

## Requirements
- R1: After reset, both length registers are zero, phase_o is 1, latch_en_o is 0 and latch_q_o is all zeros.
- R2: On a cycle with pat_start_i high, the phase becomes pat_phase_i (1 = toggle, 0 = hold). That phase then lasts pat_offset_i+1 cycles with shift_en_i high.
- R3: When an interval expires, the phase inverts. The new interval lasts toggle length + 1 shift cycles when entering toggle, and hold length + 1 shift cycles when entering hold. Both lengths are sampled from the registers at the moment of the switch.
- R4: In cycles with shift_en_i, pat_start_i and cfg_we_i all low, neither the phase nor the interval position changes.
- R5: While the hold length register holds 0, phase_o is 1 regardless of the internal phase.
- R6: A preset value of zero (offset or length) gives an interval of exactly one shift cycle.
- R7: latch_en_o equals shift_en_i while phase_o is 1 and is 0 while phase_o is 0.
- R8: On an edge where latch_en_o is high, latch_q_o takes gen_i. While phase_o is 0 and first_cycle_i is low, latch_q_o keeps its value.
- R9: An edge with first_cycle_i high loads gen_i into latch_q_o in either phase.
- R10: If pat_start_i and shift_en_i are both high, the pattern load wins over counting.
- R11: cfg_we_i loads cfg_toggle_i and cfg_hold_i into the length registers on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write both length registers |
| cfg_toggle_i | input | CNT_W | Toggle interval length |
| cfg_hold_i | input | CNT_W | Hold interval length (0 = never hold) |
| pat_start_i | input | 1 | Per-pattern initialization strobe |
| pat_phase_i | input | 1 | Starting phase (1 toggle, 0 hold) |
| pat_offset_i | input | CNT_W | Starting interval offset |
| shift_en_i | input | 1 | Scan shift cycle |
| first_cycle_i | input | 1 | End-of-initialization latch reload |
| gen_i | input | LANES | Generator word |
| phase_o | output | 1 | Current phase (1 toggle, 0 hold) |
| latch_en_o | output | 1 | Hold latch enable |
| latch_q_o | output | LANES | Hold latch contents |

## Verification
phase_o and latch_q_o are registered results. They are due one rising edge after the cycle whose inputs cause them. latch_en_o is combinational and is due in the same cycle as the inputs. The driver applies the inputs on the falling edge and checks latch_en_o one time unit later. It also pushes the expected phase and latch word for the next edge into a queue. The monitor pops and compares that item two time units after each rising edge, so every comparison sits away from both clock edges.

// File: rtl/ht_interval_pkg.sv
package ht_interval_pkg;
  typedef enum logic {
    PH_HOLD   = 1'b0,
    PH_TOGGLE = 1'b1
  } phase_e;
endpackage

// File: rtl/ht_len_regs.sv
module ht_len_regs #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] toggle_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic [CNT_W-1:0] toggle_len_o,
  output logic [CNT_W-1:0] hold_len_o,
  output logic             no_hold_o
);
  logic [CNT_W-1:0] toggle_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_q <= '0;
      hold_q   <= '0;
    end else if (we_i) begin
      toggle_q <= toggle_i;
      hold_q   <= hold_i;
    end
  end

  assign toggle_len_o = toggle_q;
  assign hold_len_o   = hold_q;
  // reserved code: zero hold length disables hold intervals
  assign no_hold_o    = (hold_q == '0);
endmodule

// File: rtl/ht_phase_ctr.sv
module ht_phase_ctr
  import ht_interval_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  phase_e           load_phase_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] toggle_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  output phase_e           phase_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           t_q, t_d;
  logic             expire;

  assign expire = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    t_d   = t_q;
    if (load_i) begin
      cnt_d = load_cnt_i;
      t_d   = load_phase_i;
    end else if (step_i) begin
      if (expire) begin
        t_d   = (t_q == PH_HOLD) ? PH_TOGGLE : PH_HOLD;
        cnt_d = (t_q == PH_HOLD) ? toggle_len_i : hold_len_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      t_q   <= PH_HOLD;
    end else begin
      cnt_q <= cnt_d;
      t_q   <= t_d;
    end
  end

  assign phase_o = t_q;
endmodule

// File: rtl/ht_latch_bank.sv
module ht_latch_bank #(
  parameter int LANES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);
  logic upd;
  assign upd = en_i | reload_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q_q <= 1'b0;
      else if (upd) q_q <= d_i[g];
    end
    assign q_o[g] = q_q;
  end
endmodule

// File: rtl/ht_interval_seq.sv
module ht_interval_seq
  import ht_interval_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LANES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_toggle_i,
  input  logic [CNT_W-1:0] cfg_hold_i,
  input  logic             pat_start_i,
  input  logic             pat_phase_i,
  input  logic [CNT_W-1:0] pat_offset_i,
  input  logic             shift_en_i,
  input  logic             first_cycle_i,
  input  logic [LANES-1:0] gen_i,
  output logic             phase_o,
  output logic             latch_en_o,
  output logic [LANES-1:0] latch_q_o
);
  logic [CNT_W-1:0] toggle_len, hold_len;
  logic             no_hold;
  phase_e           t_phase;

  ht_len_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i        (cfg_we_i),
    .toggle_i    (cfg_toggle_i),
    .hold_i      (cfg_hold_i),
    .toggle_len_o(toggle_len),
    .hold_len_o  (hold_len),
    .no_hold_o   (no_hold)
  );

  ht_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni,
    .load_i      (pat_start_i),
    .load_phase_i(phase_e'(pat_phase_i)),
    .load_cnt_i  (pat_offset_i),
    .step_i      (shift_en_i),
    .toggle_len_i(toggle_len),
    .hold_len_i  (hold_len),
    .phase_o     (t_phase)
  );

  assign phase_o    = (t_phase == PH_TOGGLE) | no_hold;
  assign latch_en_o = shift_en_i & phase_o;

  ht_latch_bank #(.LANES(LANES)) u_bank (
    .clk_i, .rst_ni,
    .en_i    (latch_en_o),
    .reload_i(first_cycle_i),
    .d_i     (gen_i),
    .q_o     (latch_q_o)
  );
endmodule

module ht_interval_seq_chk #(
  parameter int CNT_W = 4,
  parameter int LANES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CNT_W-1:0] cfg_hold_i,
  input logic             pat_start_i,
  input logic             pat_phase_i,
  input logic             shift_en_i,
  input logic             first_cycle_i,
  input logic [LANES-1:0] gen_i,
  input logic             phase_o,
  input logic [LANES-1:0] latch_q_o
);
  // R4
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !pat_start_i && !cfg_we_i) |=> $stable(phase_o));
  // R5
  no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_hold_i == '0) |=> phase_o);
  // R2
  pat_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_start_i && pat_phase_i && !cfg_we_i) |=> phase_o);
  // R8
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_o && !first_cycle_i) |=> $stable(latch_q_o));
  // R9
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_cycle_i |=> (latch_q_o == $past(gen_i)));
endmodule

bind ht_interval_seq ht_interval_seq_chk #(.CNT_W(CNT_W), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_hold_i, .pat_start_i, .pat_phase_i,
  .shift_en_i, .first_cycle_i, .gen_i, .phase_o, .latch_q_o
);

// File: tb/ht_interval_seq_tb_top.sv
module ht_interval_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int CW = 4;
  localparam int LN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, pat_start = 0, pat_phase = 0, shift_en = 0, first_cycle = 0;
  logic [CW-1:0] cfg_tog = '0, cfg_hold = '0, pat_off = '0;
  logic [LN-1:0] gen = '0;
  logic phase, len;
  logic [LN-1:0] lq;

  always #(CLK_P/2) clk = ~clk;

  ht_interval_seq #(.CNT_W(CW), .LANES(LN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_toggle_i(cfg_tog),
    .cfg_hold_i(cfg_hold), .pat_start_i(pat_start), .pat_phase_i(pat_phase),
    .pat_offset_i(pat_off), .shift_en_i(shift_en), .first_cycle_i(first_cycle),
    .gen_i(gen), .phase_o(phase), .latch_en_o(len), .latch_q_o(lq)
  );

  typedef struct {logic ph; logic [LN-1:0] lq; string req;} exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  // reference state
  logic ph_m = 0;
  int rem_m = 1;
  int tog_m = 0, hold_m = 0;
  logic [LN-1:0] lat_m = '0;

  function automatic logic vis_phase();
    return ph_m | (hold_m == 0);
  endfunction

  task automatic step(input logic we, input int tg, input int hd, input logic ps,
                      input logic pp, input int po, input logic sh, input logic fc,
                      input logic [LN-1:0] g, input string req);
    logic pre;
    int otog, ohold;
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_tog = CW'(tg); cfg_hold = CW'(hd);
    pat_start = ps; pat_phase = pp; pat_off = CW'(po);
    shift_en = sh; first_cycle = fc; gen = g;
    pre = vis_phase();
    otog = tog_m; ohold = hold_m;
    #1;
    checks++;
    if (len !== (sh & pre)) begin
      errors++;
      $display("FAIL R7 latch_en actual %0b expected %0b", len, sh & pre);
    end
    if (fc || (sh && pre)) lat_m = g;
    if (ps) begin
      ph_m = pp; rem_m = po + 1;
    end else if (sh) begin
      rem_m--;
      if (rem_m == 0) begin
        ph_m = ~ph_m;
        rem_m = (ph_m ? otog : ohold) + 1;
      end
    end
    if (we) begin tog_m = tg; hold_m = hd; end
    e.ph = vis_phase(); e.lq = lat_m; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (phase !== e.ph) begin
          errors++;
          $display("FAIL %s phase actual %0b expected %0b", e.req, phase, e.ph);
        end
        checks++;
        if (lq !== e.lq) begin
          errors++;
          $display("FAIL %s latch actual %h expected %h", e.req, lq, e.lq);
        end
      end
    end
  end

  function automatic logic [LN-1:0] pat(input int i);
    return LN'(32'hA5C3 ^ (i * 32'h1357));
  endfunction

  logic done = 0;
  initial begin : watchdog
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    // R1
    if (phase !== 1'b1 || len !== 1'b0 || lq !== '0) begin
      errors++;
      $display("FAIL R1 actual ph=%0b en=%0b lq=%h expected 1 0 0", phase, len, lq);
    end
    // R11 program toggle=2, hold=3
    step(1, 2, 3, 0, 0, 0, 0, 0, '0, "R11");
    // R2 start in toggle, offset 1
    step(0, 0, 0, 1, 1, 1, 0, 0, '0, "R2");
    // R3 R8 alternating intervals
    for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 0, 0, 1, 0, pat(i), "R3");
    // R4 idle
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, pat(i + 40), "R4");
    // start in hold, offset 2
    step(0, 0, 0, 1, 0, 2, 0, 0, '0, "R2");
    step(0, 0, 0, 0, 0, 0, 1, 0, pat(50), "R8");
    // R9 reload during hold
    step(0, 0, 0, 0, 0, 0, 0, 1, pat(51), "R9");
    step(0, 0, 0, 0, 0, 0, 1, 1, pat(52), "R9");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 0, pat(60 + i), "R3");
    // R10 R6 start with shift, hold offset 0
    step(0, 0, 0, 1, 0, 0, 1, 0, pat(70), "R10");
    step(0, 0, 0, 0, 0, 0, 1, 0, pat(71), "R6");
    step(0, 0, 0, 0, 0, 0, 1, 0, pat(72), "R6");
    // R6 zero lengths: toggle=0 hold=1
    step(1, 0, 1, 0, 0, 0, 0, 0, '0, "R11");
    step(0, 0, 0, 1, 1, 0, 0, 0, '0, "R2");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 1, 0, pat(80 + i), "R6");
    // R5 hold length zero
    step(1, 5, 0, 0, 0, 0, 0, 0, '0, "R5");
    step(0, 0, 0, 1, 0, 3, 0, 0, '0, "R5");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 0, 1, 0, pat(90 + i), "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, "R4");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule